// File: doc/BRIEF.md
# Pulse High-Width Capture Timer

This block is a single timer channel that measures how long an asynchronous input stays high, in units of a count-clock enable. Software arms it with a one-cycle start write. Each rising edge seen on the conditioned input clears the counter and starts the measurement. The next falling edge copies the count into a capture register and raises a one-cycle interrupt. After a capture the channel waits for the next rising edge on its own, so it measures pulse after pulse without another start write.

The input passes through a two-flop synchronizer. After that it can go through a digital noise filter, which is switched in with a level input. The filter takes a new input level only when that level has been the same for two earlier count-clock samples as well as the current one. This rejects short glitches, and it delays every detected edge by two count-clock samples. If the count runs past its maximum, it wraps and sets a sticky overflow flag. The flag clears on the next start of a measurement. A stop write returns the channel to idle at once and leaves the capture register unchanged.

Top module: `hwt_top`

## Requirements
- R1: After reset, chanEn, capIrq and ovfFlag are 0 and capData is 0.
- R2: A startWr pulse sets chanEn to 1 from the next cycle. A stopWr pulse clears it from the next cycle. When both are written in the same cycle, stopWr wins.
- R3: While chanEn is 0, input pulses raise no capIrq and leave capData unchanged. A stop during a measurement cancels that measurement.
- R4: The captured value equals the number of count enables strictly after the rising-edge detection and strictly before the falling-edge detection. With cntEn held at 1 and tIn high for H clock cycles, capData becomes H-1, both with and without the filter.
- R5: capIrq is high for exactly one cycle per capture. capData changes only in a cycle where capIrq is high.
- R6: After a capture, the channel measures further pulses without a new startWr.
- R7: With cntEn held at 1, capIrq rises on the 3rd clock edge after tIn falls without the filter, and on the 5th with the filter.
- R8: With the filter on and cntEn held at 1, high pulses of 1 or 2 cycles produce no capture. Without the filter, a 1-cycle pulse is captured as 0.
- R9: When the counter increments from FFFFh it wraps to 0000h and ovfFlag becomes 1. The flag stays at 1 through the capture and clears at the next rising-edge start.
- R10: During a measurement, cycles with cntEn at 0 do not change the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| cntEn | input | 1 | Count-clock enable; sampling and counting happen only in cycles where it is 1 |
| startWr | input | 1 | One-cycle start write; arms the channel |
| stopWr | input | 1 | One-cycle stop write; returns the channel to idle |
| filtEn | input | 1 | Switches the noise filter into the input path |
| tIn | input | 1 | Asynchronous timer input being measured |
| capData | output | 16 | Last captured high width |
| capIrq | output | 1 | One-cycle capture interrupt |
| chanEn | output | 1 | Channel enable status |
| ovfFlag | output | 1 | Sticky counter wrap flag for the current measurement |

## Verification
Some properties are checked by assertions on every cycle. The interrupt is never longer than one cycle, and the capture register moves only together with it. No interrupt follows a cycle in which the channel was disabled. A stop always clears the enable. The counter never moves in a cycle without a count enable, and the overflow flag rises only right after the counter held its maximum. Other behaviour can only be shown by the bench's scenarios: the exact captured widths, the two-sample delay added by the filter, the rejection of short glitches, the automatic re-arming, and the wrap of a measurement longer than 65535 counts.

// File: rtl/hwt_pkg.sv
package hwt_pkg;
  localparam int CNT_W = 16;

  typedef struct packed {
    logic clr;   // start trigger: load zero, drop overflow
    logic inc;   // advance the counter one step
    logic cap;   // copy counter into the capture register
  } dpCmd_t;
endpackage

// File: rtl/hwt_input_cond.sv
module hwt_input_cond #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic cntEn,
  input  logic filtEn,
  input  logic tIn,
  output logic riseDet,
  output logic fallDet
);
  logic [SYNC_STAGES-1:0] syncQ;
  logic [FILT_LEN-1:0]    histQ;
  logic                   syncOut;
  logic                   steady;
  logic                   lvlQ;
  logic                   nextLvl;

  always_ff @(posedge clk) begin
    if (!rstN) syncQ <= '0;
    else       syncQ <= {syncQ[SYNC_STAGES-2:0], tIn};
  end

  assign syncOut = syncQ[SYNC_STAGES-1];

  // the history of count-clock samples feeding the filter
  always_ff @(posedge clk) begin
    if (!rstN)      histQ <= '0;
    else if (cntEn) histQ <= {histQ[FILT_LEN-2:0], syncOut};
  end

  assign steady  = syncOut ? (&histQ) : ~(|histQ);
  assign nextLvl = filtEn ? (steady ? syncOut : lvlQ) : syncOut;

  always_ff @(posedge clk) begin
    if (!rstN)      lvlQ <= 1'b0;
    else if (cntEn) lvlQ <= nextLvl;
  end

  assign riseDet = cntEn & nextLvl & ~lvlQ;
  assign fallDet = cntEn & ~nextLvl & lvlQ;
endmodule

// File: rtl/hwt_ctrl.sv
module hwt_ctrl
  import hwt_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   cntEn,
  input  logic   startWr,
  input  logic   stopWr,
  input  logic   riseDet,
  input  logic   fallDet,
  output dpCmd_t cmd,
  output logic   chanEn
);
  typedef enum logic [1:0] {ST_IDLE, ST_ARMED, ST_MEAS} chState_t;
  chState_t stateQ, stateD;

  always_comb begin
    stateD = stateQ;
    cmd    = '0;
    if (stopWr) begin
      stateD = ST_IDLE;
    end else if (startWr) begin
      stateD = ST_ARMED;
    end else begin
      unique case (stateQ)
        ST_ARMED: if (riseDet) begin
          cmd.clr = 1'b1;
          stateD  = ST_MEAS;
        end
        ST_MEAS: begin
          if (fallDet) begin
            cmd.cap = 1'b1;
            stateD  = ST_ARMED;
          end else begin
            cmd.inc = cntEn;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  assign chanEn = (stateQ != ST_IDLE);

  // R2
  stop_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    stopWr |=> !chanEn);
endmodule

// File: rtl/hwt_datapath.sv
module hwt_datapath
  import hwt_pkg::*;
#(
  parameter int CW = CNT_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  dpCmd_t        cmd,
  output logic [CW-1:0] cntVal,
  output logic [CW-1:0] capVal,
  output logic          irqOut,
  output logic          ovfOut
);
  logic [CW-1:0] cntQ;
  logic [CW-1:0] capQ;
  logic          irqQ;
  logic          ovfQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ <= '0;
      ovfQ <= 1'b0;
    end else if (cmd.clr) begin
      cntQ <= '0;
      ovfQ <= 1'b0;
    end else if (cmd.inc) begin
      cntQ <= cntQ + 1'b1;
      if (cntQ == '1) ovfQ <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      capQ <= '0;
      irqQ <= 1'b0;
    end else begin
      irqQ <= cmd.cap;
      if (cmd.cap) capQ <= cntQ;
    end
  end

  assign cntVal = cntQ;
  assign capVal = capQ;
  assign irqOut = irqQ;
  assign ovfOut = ovfQ;

  // R5
  irq_single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqQ |=> !irqQ);

  // R5
  cap_moves_with_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(capQ) |-> irqQ);

  // R9
  ovf_after_max_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ovfQ) |-> ($past(cntQ) == '1));
endmodule

// File: rtl/hwt_top.sv
module hwt_top
  import hwt_pkg::*;
#(
  parameter int CW          = CNT_W,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cntEn,
  input  logic          startWr,
  input  logic          stopWr,
  input  logic          filtEn,
  input  logic          tIn,
  output logic [CW-1:0] capData,
  output logic          capIrq,
  output logic          chanEn,
  output logic          ovfFlag
);
  logic          riseDet;
  logic          fallDet;
  dpCmd_t        cmd;
  logic [CW-1:0] cntVal;

  hwt_input_cond #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_cond (
    .clk(clk), .rstN(rstN), .cntEn(cntEn), .filtEn(filtEn), .tIn(tIn),
    .riseDet(riseDet), .fallDet(fallDet)
  );

  hwt_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cntEn(cntEn), .startWr(startWr), .stopWr(stopWr),
    .riseDet(riseDet), .fallDet(fallDet), .cmd(cmd), .chanEn(chanEn)
  );

  hwt_datapath #(.CW(CW)) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .cntVal(cntVal),
    .capVal(capData), .irqOut(capIrq), .ovfOut(ovfFlag)
  );

  // R3
  irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    capIrq |-> $past(chanEn));

  // R10
  count_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cntEn |=> $stable(cntVal));
endmodule

// File: tb/tb_hwt_top.sv
module tb_hwt_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cntEn = 1'b1;
  logic        startWr = 1'b0;
  logic        stopWr = 1'b0;
  logic        filtEn = 1'b0;
  logic        tIn = 1'b0;
  logic [15:0] capData;
  logic        capIrq;
  logic        chanEn;
  logic        ovfFlag;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  hwt_top dut (
    .clk(clk), .rstN(rstN), .cntEn(cntEn), .startWr(startWr), .stopWr(stopWr),
    .filtEn(filtEn), .tIn(tIn), .capData(capData), .capIrq(capIrq),
    .chanEn(chanEn), .ovfFlag(ovfFlag)
  );

  // bit 16: filter on; bits 15:0: high width in clocks
  localparam int VEC_N = 6;
  localparam logic [16:0] VEC [VEC_N] = '{
    {1'b0, 16'd1}, {1'b0, 16'd5}, {1'b0, 16'd40},
    {1'b1, 16'd3}, {1'b1, 16'd9}, {1'b1, 16'd100}
  };

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic writeStart();
    startWr = 1'b1;
    @(negedge clk);
    startWr = 1'b0;
  endtask

  // waits for the capture after tIn falls; reports how many irq cycles and the first one
  task automatic watchIrq(output int irqs, output int lat);
    irqs = 0;
    lat  = 0;
    for (int k = 1; k <= 12; k++) begin
      @(negedge clk);
      if (capIrq) begin
        irqs++;
        if (lat == 0) lat = k;
      end
    end
  endtask

  task automatic pulse(input int hi, output int irqs, output int lat);
    tIn = 1'b1;
    repeat (hi) @(negedge clk);
    tIn = 1'b0;
    watchIrq(irqs, lat);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog act=1 exp=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int irqs, lat, prev;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1
    check("R1 chanEn", int'(chanEn), 0);
    check("R1 capIrq", int'(capIrq), 0);
    check("R1 ovfFlag", int'(ovfFlag), 0);
    check("R1 capData", int'(capData), 0);

    // R3: pulse while idle is ignored
    pulse(6, irqs, lat);
    check("R3 idle irq", irqs, 0);
    check("R3 idle capData", int'(capData), 0);

    // R2
    writeStart();
    check("R2 start", int'(chanEn), 1);

    // R4 R5 R6 R7 R8: table walk with a single start write
    for (int i = 0; i < VEC_N; i++) begin
      filtEn = VEC[i][16];
      repeat (4) @(negedge clk);
      pulse(int'(VEC[i][15:0]), irqs, lat);
      check("R5 R6 one irq", irqs, 1);
      check("R4 width", int'(capData), int'(VEC[i][15:0]) - 1);
      check("R7 latency", lat, VEC[i][16] ? 5 : 3);
    end

    // R8: short glitches rejected by the filter
    filtEn = 1'b1;
    repeat (4) @(negedge clk);
    prev = int'(capData);
    pulse(1, irqs, lat);
    check("R8 glitch1 irq", irqs, 0);
    pulse(2, irqs, lat);
    check("R8 glitch2 irq", irqs, 0);
    check("R8 capData kept", int'(capData), prev);
    filtEn = 1'b0;
    repeat (4) @(negedge clk);

    // R10: cntEn low for 5 clocks during a 20-clock pulse
    tIn = 1'b1;
    repeat (7) @(negedge clk);
    cntEn = 1'b0;
    repeat (5) @(negedge clk);
    cntEn = 1'b1;
    repeat (8) @(negedge clk);
    tIn = 1'b0;
    watchIrq(irqs, lat);
    check("R10 irq", irqs, 1);
    check("R10 frozen count", int'(capData), 14);

    // R9: wrap past FFFFh
    pulse(65540, irqs, lat);
    check("R9 irq", irqs, 1);
    check("R9 wrapped", int'(capData), 3);
    check("R9 sticky", int'(ovfFlag), 1);
    pulse(5, irqs, lat);
    check("R9 cleared", int'(ovfFlag), 0);
    check("R9 next width", int'(capData), 4);

    // R3: stop in mid-measurement cancels it
    prev = int'(capData);
    tIn = 1'b1;
    repeat (10) @(negedge clk);
    stopWr = 1'b1;
    @(negedge clk);
    stopWr = 1'b0;
    check("R2 stop", int'(chanEn), 0);
    tIn = 1'b0;
    watchIrq(irqs, lat);
    check("R3 stopped irq", irqs, 0);
    check("R3 stopped capData", int'(capData), prev);

    // R2: simultaneous start and stop
    writeStart();
    check("R2 restart", int'(chanEn), 1);
    startWr = 1'b1;
    stopWr  = 1'b1;
    @(negedge clk);
    startWr = 1'b0;
    stopWr  = 1'b0;
    check("R2 stop wins", int'(chanEn), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule